// File: doc/BRIEF.md
# NAND Command/Address Cycle Bridge

This block connects a 32-bit memory-mapped host bus to an 8-bit asynchronous NAND flash port. A host access to the NAND window turns into one or more NAND byte cycles. Two host address bits decide how a byte is latched by the flash. Byte-address bit 3 raises the address-latch enable, and byte-address bit 4 raises the command-latch enable. With neither bit set, the access is a plain data transfer. Halfword and word accesses are split into back-to-back byte cycles, least-significant byte first. The two lowest address bits play no part in a NAND access.

Four chip-select windows are decoded from host address bits [9:8]. Address bit 5 moves the access from the primary enable of that window to its secondary enable, as used for a second die in a multi-chip package. A small register space, selected by address bit 12, holds a control register and a status register. Control bit N enables NAND operation on window N. Status bit 0 shows the shared wire-AND ready/busy line, brought in through a two-flop synchronizer. The host holds `req_i` and its fields until `ack_o` pulses for one cycle, and read data is valid in that cycle.

Top module: `nandb_bridge`

## Requirements
- R1: During a NAND access, the ALE output equals host address bit 3 and the CLE output equals host address bit 4. Both stay stable through every strobe. With both bits clear, ALE and CLE are low.
- R2: Host size code 0 (byte) gives 1 byte cycle, code 1 (halfword) gives 2, and code 2 (word) gives 4. Address bits [1:0] have no effect on a NAND access.
- R3: Each byte cycle has 1 clock of setup, 2 clocks of strobe and 1 clock of hold, and chip enable is low throughout. Write enable (for writes) or read enable (for reads) is low only during the strobe. A NAND access of N bytes is acknowledged 4·N clocks after the clock edge that accepts it.
- R4: On a write, byte i of the host word (bits 8i+7..8i) is driven in byte cycle i. The data output enable is high whenever write enable is low.
- R5: On a read, the byte sampled in cycle i is placed in bits 8i+7..8i of the returned word, and unused upper bytes read as 0. `ack_o` is high for exactly one clock, only after the last cycle's hold.
- R6: When host address bit 5 is set, the secondary enable of the selected window goes low instead of its primary enable.
- R7: Address bits [9:8] select the window. At most one of the eight enables is low at any time, and all are high when no NAND access is running.
- R8: An access to a window whose control bit is 0 produces no strobe, is acknowledged one clock after acceptance, and reads as 0.
- R9: A host access with address bit 12 set uses the register space, and address bit 2 selects the register (0 = control, 1 = status). Status bit 0 equals the ready/busy input as seen through two clock stages: 1 = ready, 0 = busy.
- R10: After reset, all enables and strobes are high, ALE and CLE are low, and the control register reads 0. The control register reads back the value last written to its bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until acknowledged |
| we_i | input | 1 | Host write (1) or read (0) |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_i | input | 13 | Host byte address |
| wdata_i | input | 32 | Host write data |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Read data, valid with ack_o |
| nand_ce_no | output | 4 | Primary chip enables, active low |
| nand_ce2_no | output | 4 | Secondary chip enables, active low |
| nand_ale_o | output | 1 | Address latch enable |
| nand_cle_o | output | 1 | Command latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | NAND data out |
| nand_dq_oe_o | output | 1 | NAND data output enable |
| nand_dq_i | input | 8 | NAND data in |
| nand_rb_i | input | 1 | Shared ready/busy, 1 = ready |

## Verification
The hardest case to observe from the ports is the shape of every byte cycle inside a multi-byte access. The setup before each strobe, the strobe length, and the hold with chip enable still low are only visible between the request and the acknowledge. A negative-edge monitor follows the strobe lines through every table access and records each strobe's length, the control and enable pattern, and the data byte. It also checks that chip enable was already low one clock before each strobe and is still low one clock after it. The flash model returns a byte that changes after every read strobe, so a wrong byte order or a missing cycle shows up as a wrong returned word. The synchronizer delay is checked by reading status in the first clock after the ready line drops, then again two clocks later.

// File: rtl/nandb_pkg.sv
package nandb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } host_size_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // index of the final byte cycle for a host size code
  function automatic logic [1:0] size_last(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_last = 2'd0;
      SZ_HALF: size_last = 2'd1;
      default: size_last = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/nandb_sync.sv
module nandb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nandb_regs.sv
module nandb_regs #(
  parameter int NCS = 4,
  parameter int DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           sel_stat_i,
  input  logic [NCS-1:0] wdata_i,
  input  logic           ready_i,
  output logic [NCS-1:0] mode_o,
  output logic [DW-1:0]  rdata_o
);
  logic [NCS-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mode_q <= '0;
    else if (wr_i && !sel_stat_i) mode_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat_i) rdata_o[0] = ready_i;
    else            rdata_o[NCS-1:0] = mode_q;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/nandb_cycle.sv
module nandb_cycle
  import nandb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  localparam int NB        = DW / 8,
  localparam int IW        = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [IW-1:0] last_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [7:0]    dq_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_no,
  output logic          re_no,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PMAX = (SETUP_CYC > STROBE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW = $clog2(PMAX) + 1;

  phase_e               phase_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q, last_q;
  logic                 wr_q, done_q;
  logic [NB-1:0][7:0]   wbuf_q, rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= '0;
          idx_q   <= '0;
          last_q  <= last_i;
          wr_q    <= write_i;
          wbuf_q  <= wdata_i;
          rbuf_q  <= '0;
        end
        PH_SETUP: begin
          if (cnt_q == CW'(SETUP_CYC - 1)) begin
            phase_q <= PH_STROBE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_STROBE: begin
          if (cnt_q == CW'(STROBE_CYC - 1)) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
            if (!wr_q) rbuf_q[idx_q] <= dq_i; // sample at strobe release
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_HOLD: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            cnt_q <= '0;
            if (idx_q == last_q) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_SETUP;
              idx_q   <= idx_q + 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
  assign we_no   = !((phase_q == PH_STROBE) && wr_q);
  assign re_no   = !((phase_q == PH_STROBE) && !wr_q);
  assign dq_o    = wbuf_q[idx_q];
  assign dq_oe_o = busy_o && wr_q;
  assign rdata_o = rbuf_q;
endmodule

// File: rtl/nandb_bridge.sv
module nandb_bridge
  import nandb_pkg::*;
#(
  parameter int AW          = 13,
  parameter int NCS         = 4,
  parameter int CS_LSB      = 8,
  parameter int SEC_BIT     = 5,
  parameter int ALE_BIT     = 3,
  parameter int CLE_BIT     = 4,
  parameter int REG_BIT     = 12,
  parameter int REG_SEL_BIT = 2,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [1:0]     size_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic           ack_o,
  output logic [31:0]    rdata_o,
  output logic [NCS-1:0] nand_ce_no,
  output logic [NCS-1:0] nand_ce2_no,
  output logic           nand_ale_o,
  output logic           nand_cle_o,
  output logic           nand_we_no,
  output logic           nand_re_no,
  output logic [7:0]     nand_dq_o,
  output logic           nand_dq_oe_o,
  input  logic [7:0]     nand_dq_i,
  input  logic           nand_rb_i
);
  localparam int DW  = 32;
  localparam int IW  = $clog2(DW / 8);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  logic           rb_sync;
  logic [NCS-1:0] mode;
  logic [DW-1:0]  reg_rdata, cyc_rdata;
  logic           cyc_busy, cyc_done;
  logic           accept, is_reg, start, reg_wr;
  logic [CSW-1:0] cs_idx, cs_q;
  logic           sec_q, ale_q, cle_q, ack_q;
  logic [DW-1:0]  rdata_q;
  logic           addr_unused;

  assign addr_unused = ^{addr_i, wdata_i};

  nandb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nand_rb_i),
    .q_o   (rb_sync)
  );

  assign accept = req_i && !cyc_busy && !ack_o;
  assign is_reg = addr_i[REG_BIT];
  assign cs_idx = addr_i[CS_LSB +: CSW];
  assign start  = accept && !is_reg && mode[cs_idx];
  assign reg_wr = accept && is_reg && we_i;

  nandb_regs #(.NCS(NCS), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr),
    .sel_stat_i(addr_i[REG_SEL_BIT]),
    .wdata_i   (wdata_i[NCS-1:0]),
    .ready_i   (rb_sync),
    .mode_o    (mode),
    .rdata_o   (reg_rdata)
  );

  nandb_cycle #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_cycle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .write_i(we_i),
    .last_i (IW'(size_last(size_i))),
    .wdata_i(wdata_i),
    .dq_i   (nand_dq_i),
    .busy_o (cyc_busy),
    .done_o (cyc_done),
    .we_no  (nand_we_no),
    .re_no  (nand_re_no),
    .dq_o   (nand_dq_o),
    .dq_oe_o(nand_dq_oe_o),
    .rdata_o(cyc_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      sec_q   <= 1'b0;
      ale_q   <= 1'b0;
      cle_q   <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= accept && !start;  // register access or disabled window
      if (accept && !start) rdata_q <= is_reg ? reg_rdata : '0;
      if (start) begin
        cs_q  <= cs_idx;
        sec_q <= addr_i[SEC_BIT];
        ale_q <= addr_i[ALE_BIT];
        cle_q <= addr_i[CLE_BIT];
      end
    end
  end

  assign ack_o      = ack_q || cyc_done;
  assign rdata_o    = cyc_done ? cyc_rdata : rdata_q;
  assign nand_ale_o = cyc_busy && ale_q;
  assign nand_cle_o = cyc_busy && cle_q;

  for (genvar g = 0; g < NCS; g++) begin : g_ce
    assign nand_ce_no[g]  = !(cyc_busy && (cs_q == CSW'(g)) && !sec_q);
    assign nand_ce2_no[g] = !(cyc_busy && (cs_q == CSW'(g)) && sec_q);
  end
endmodule

// File: rtl/nandb_bridge_chk.sv
module nandb_bridge_chk #(
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ack_o,
  input logic [NCS-1:0] nand_ce_no,
  input logic [NCS-1:0] nand_ce2_no,
  input logic           nand_ale_o,
  input logic           nand_cle_o,
  input logic           nand_we_no,
  input logic           nand_re_no,
  input logic           nand_dq_oe_o
);
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  assert_we_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_we_no) |=> !nand_we_no ##1 nand_we_no);

  assert_re_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_re_no) |=> !nand_re_no ##1 nand_re_no);

  assert_latch_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) && $past(!nand_we_no || !nand_re_no)
      |-> $stable(nand_ale_o) && $stable(nand_cle_o));

  assert_oe_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> nand_dq_oe_o);

  assert_single_ce_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{nand_ce2_no, nand_ce_no}));

  assert_strobe_has_ce_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !(&{nand_ce2_no, nand_ce_no}));

  assert_ack_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ack_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (&nand_ce_no) && (&nand_ce2_no) && nand_we_no && nand_re_no);
endmodule

bind nandb_bridge nandb_bridge_chk #(.NCS(NCS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .nand_ce_no  (nand_ce_no),
  .nand_ce2_no (nand_ce2_no),
  .nand_ale_o  (nand_ale_o),
  .nand_cle_o  (nand_cle_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nandb_bridge_test.sv
`timescale 1ns/1ps
module nandb_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [12:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic [3:0]  nand_ce_no, nand_ce2_no;
  logic        nand_ale_o, nand_cle_o, nand_we_no, nand_re_no, nand_dq_oe_o;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb_i = 1'b1;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk_i = ~clk_i;

  nandb_bridge uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .nand_ce_no(nand_ce_no), .nand_ce2_no(nand_ce2_no), .nand_ale_o(nand_ale_o),
    .nand_cle_o(nand_cle_o), .nand_we_no(nand_we_no), .nand_re_no(nand_re_no),
    .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o), .nand_dq_i(nand_dq_i),
    .nand_rb_i(nand_rb_i)
  );

  // flash model: read byte advances after each read strobe
  int rd_cnt = 0;
  assign nand_dq_i = 8'h30 + 8'(rd_cnt);

  // negedge monitor of byte cycles
  logic       exp_ale, exp_cle, exp_sec;
  logic [1:0] exp_cs;
  int strobes, bad_ctl, bad_ce, bad_shape, bad_oe, run;
  logic [7:0] wb [4];
  logic prev_low = 1'b0, prev_re_low = 1'b0, prev_ce_low = 1'b0;

  always @(negedge clk_i) begin
    logic low, ce_low;
    low    = !nand_we_no || !nand_re_no;
    ce_low = !(&{nand_ce2_no, nand_ce_no});
    if (low && !prev_low) begin
      if (!prev_ce_low) bad_shape++;
      if (!nand_we_no) begin
        if (strobes < 4) wb[strobes] = nand_dq_o;
        if (!nand_dq_oe_o) bad_oe++;
      end
      if (nand_ale_o !== exp_ale || nand_cle_o !== exp_cle) bad_ctl++;
      if (nand_ce_no  !== (exp_sec ? 4'hF : ~(4'h1 << exp_cs)) ||
          nand_ce2_no !== (exp_sec ? ~(4'h1 << exp_cs) : 4'hF)) bad_ce++;
      strobes++;
      run = 1;
    end else if (low) begin
      run++;
    end
    if (!low && prev_low) begin
      if (run != 2) bad_shape++;
      if (!ce_low) bad_shape++;
      if (prev_re_low) rd_cnt++;
    end
    prev_low    = low;
    prev_re_low = !nand_re_no;
    prev_ce_low = ce_low;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [12:0] a,
                     input logic [31:0] d, output int lat, output logic [31:0] rd);
    @(negedge clk_i);
    exp_ale = a[3]; exp_cle = a[4]; exp_sec = a[5]; exp_cs = a[9:8];
    strobes = 0; bad_ctl = 0; bad_ce = 0; bad_shape = 0; bad_oe = 0;
    req_i = 1'b1; we_i = w; size_i = sz; addr_i = a; wdata_i = d;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!ack_o && lat < 200);
    rd = rdata_o;
    req_i = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [12:0] addr;
    logic [31:0] wd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 13'h010, 32'h0000_0070},  // command byte, cs0
    '{1'b1, 2'd0, 13'h108, 32'h0000_005A},  // address byte, cs1
    '{1'b1, 2'd2, 13'h200, 32'h4433_2211},  // data word, cs2
    '{1'b1, 2'd1, 13'h323, 32'h0000_BEEF},  // half, secondary cs3, low bits set
    '{1'b0, 2'd2, 13'h000, 32'h0},          // read word cs0
    '{1'b0, 2'd1, 13'h103, 32'h0},          // read half cs1, low bits set
    '{1'b0, 2'd0, 13'h020, 32'h0},          // read byte secondary cs0
    '{1'b1, 2'd2, 13'h128, 32'hDEAD_BEEF}   // address word, secondary cs1
  };

  initial begin
    int lat;
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    chk(nand_ce_no == 4'hF && nand_ce2_no == 4'hF, "R10 enables in reset",
        {nand_ce2_no, nand_ce_no}, 32'hFF);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(nand_we_no && nand_re_no && !nand_ale_o && !nand_cle_o && !ack_o,
        "R10 idle strobes", {nand_we_no, nand_re_no, nand_ale_o, nand_cle_o, ack_o}, 32'h18);

    acc(1'b0, 2'd2, 13'h1000, 32'h0, lat, rd);
    chk(rd == 32'h0, "R10 control reset value", rd, 0);
    chk(lat == 1, "R9 register latency", lat, 1);

    acc(1'b1, 2'd0, 13'h010, 32'h70, lat, rd);
    chk(lat == 1 && strobes == 0, "R8 disabled after reset", strobes, 0);

    acc(1'b1, 2'd2, 13'h1000, 32'hFFFF_FFFF, lat, rd);
    acc(1'b0, 2'd2, 13'h1000, 32'h0, lat, rd);
    chk(rd == 32'hF, "R10 control readback", rd, 32'hF);

    for (int v = 0; v < 8; v++) begin
      int n, c0;
      logic [31:0] exp;
      n  = (VECS[v].sz == 2'd0) ? 1 : (VECS[v].sz == 2'd1) ? 2 : 4;
      c0 = rd_cnt;
      acc(VECS[v].we, VECS[v].sz, VECS[v].addr, VECS[v].wd, lat, rd);
      chk(lat == 4 * n + 1, "R3 access latency", lat, 4 * n + 1);
      chk(strobes == n, "R2 byte cycle count", strobes, n);
      chk(bad_shape == 0, "R3 setup/strobe/hold shape", bad_shape, 0);
      chk(bad_ctl == 0, "R1 ALE/CLE during strobe", bad_ctl, 0);
      chk(bad_ce == 0, "R6 R7 chip enable pattern", bad_ce, 0);
      if (VECS[v].we) begin
        chk(bad_oe == 0, "R4 output enable", bad_oe, 0);
        for (int i = 0; i < n; i++)
          chk(wb[i] == VECS[v].wd[8*i +: 8], "R4 write byte order", wb[i],
              VECS[v].wd[8*i +: 8]);
      end else begin
        exp = '0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = 8'h30 + 8'(c0 + i);
        chk(rd == exp, "R5 read assembly", rd, exp);
      end
      @(negedge clk_i);
      chk(!ack_o && (&nand_ce_no) && (&nand_ce2_no), "R7 idle after access",
          {ack_o, nand_ce2_no, nand_ce_no}, 32'hFF);
    end

    acc(1'b1, 2'd2, 13'h1000, 32'h0000_000B, lat, rd);
    acc(1'b1, 2'd2, 13'h200, 32'h1234_5678, lat, rd);
    chk(lat == 1 && strobes == 0, "R8 disabled window write", strobes, 0);
    acc(1'b0, 2'd2, 13'h200, 32'h0, lat, rd);
    chk(rd == 32'h0 && strobes == 0, "R8 disabled window read", rd, 0);
    acc(1'b0, 2'd0, 13'h000, 32'h0, lat, rd);
    chk(strobes == 1 && lat == 5, "R8 other window still enabled", strobes, 1);
    acc(1'b0, 2'd2, 13'h1000, 32'h0, lat, rd);
    chk(rd == 32'hB, "R10 control readback 2", rd, 32'hB);

    acc(1'b0, 2'd2, 13'h1004, 32'h0, lat, rd);
    chk(rd == 32'h1, "R9 status ready", rd, 1);
    nand_rb_i = 1'b0;
    acc(1'b0, 2'd2, 13'h1004, 32'h0, lat, rd);
    chk(rd == 32'h1, "R9 synchronizer delay", rd, 1);
    acc(1'b0, 2'd2, 13'h1004, 32'h0, lat, rd);
    chk(rd == 32'h0, "R9 status busy", rd, 0);
    nand_rb_i = 1'b1;
    repeat (3) @(negedge clk_i);
    acc(1'b0, 2'd2, 13'h1004, 32'h0, lat, rd);
    chk(rd == 32'h1, "R9 status ready again", rd, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule